// File: doc/BRIEF.md
# Bidirectional Thermometer-Code Shift Register

This block holds a thermometer code: a contiguous run of ones beginning at stage 0 (the least significant bit of the output vector), followed by zeros up to the top stage. Each enabled step moves the ones/zeros boundary by one position. A direction input picks the kind of step. A rightward step grows the run of ones by writing a '1' into the first zero stage. A leftward step shrinks the run by writing a '0' into the last one stage.

Every stage takes its rightward value from its lower neighbour and its leftward value from its upper neighbour. A '1' enters at stage 0 and a '0' enters at the top stage. The stages are split into an even-indexed group and an odd-indexed group. A group generator produces four update enables, one per group for each direction. Only the group holding the stage that must change is enabled, so repeated steps in one direction alternate between the two groups. No two enables are ever active together.

Synchronous clear and fill inputs empty or saturate the whole register. A step against a limit does not wrap. The block reports that case on a one-cycle flag. A separate counter reports the number of ones.

Top module: `thermo_shifter`

## Requirements
- R1: While `rst_n` is low, `code` is all zeros, `ones` is 0 and `clipped` is 0.
- R2: `clr` high at a clock edge makes `code` all zeros and `ones` 0 after that edge, whatever `fill` and `step_en` are.
- R3: `fill` high with `clr` low makes `code` all ones and `ones` equal to WIDTH after that edge, whatever `step_en` is.
- R4: With `step_en` high, `dir_left` 0, `clr` and `fill` low, and `ones` below WIDTH, stage number `ones` becomes 1 and `ones` rises by one after the edge.
- R5: With `step_en` high, `dir_left` 1, `clr` and `fill` low, and `ones` above 0, stage number `ones`-1 becomes 0 and `ones` falls by one after the edge.
- R6: With `step_en`, `clr` and `fill` all low, `code` and `ones` keep their values.
- R7: A rightward step when `ones` equals WIDTH, or a leftward step when `ones` is 0, leaves `code` unchanged and sets `clipped` to 1 for the following cycle. In every other case `clipped` is 0.
- R8: `code` is always a valid thermometer code, with no 1 above a 0, and `ones` always equals the number of set bits in `code`.
- R9: At most one of the four group enables is active in any cycle, and only one belonging to the selected direction. Two successive steps in the same direction use opposite groups, so two rightward steps from empty set stages 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear to all zeros (highest priority) |
| fill | input | 1 | Synchronous fill to all ones |
| step_en | input | 1 | Perform one step this cycle |
| dir_left | input | 1 | 0 = rightward step (grow ones), 1 = leftward step (shrink ones) |
| code | output | WIDTH | Stage contents, stage 0 at bit 0 |
| ones | output | $clog2(WIDTH+1) | Number of ones in `code` |
| clipped | output | 1 | Previous step was blocked at a limit |

## Verification
A wrong group enable shows up in one of two ways. A stage that should change holds its value, or a stage of the wrong parity takes its neighbour's value. Either way, `code` stops matching the thermometer pattern for `ones`, or the vector and the count disagree. The mismatch appears on the ports on the edge after the faulty step. Limit handling errors show as a wrap of `code` or a missing `clipped` pulse one cycle after a saturated step. The stimulus therefore drives long runs in each direction into both limits and mixes them with random clear and fill.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
    localparam int NUM_GRP_EN = 4;
    localparam int GRP_EVEN_R = 0;
    localparam int GRP_ODD_R  = 1;
    localparam int GRP_EVEN_L = 2;
    localparam int GRP_ODD_L  = 3;
endpackage

// File: rtl/thermo_group_gen.sv
module thermo_group_gen
    import thermo_pkg::*;
#(
    parameter int WIDTH = 64,
    localparam int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic                  clr,
    input  logic                  fill,
    input  logic                  step_en,
    input  logic                  dir_left,
    input  logic [CNT_W-1:0]      ones,
    output logic [NUM_GRP_EN-1:0] grp_en,
    output logic                  blocked
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WIDTH);

    logic active;
    logic at_full;
    logic at_empty;

    always_comb begin
        active   = step_en && !clr && !fill;
        at_full  = (ones == FULL);
        at_empty = (ones == '0);
        grp_en   = '0;
        blocked  = 1'b0;
        if (active) begin
            if (!dir_left) begin
                // stage to set is index 'ones'
                if (at_full) blocked = 1'b1;
                else if (ones[0]) grp_en[GRP_ODD_R] = 1'b1;
                else grp_en[GRP_EVEN_R] = 1'b1;
            end else begin
                // stage to clear is index 'ones-1'
                if (at_empty) blocked = 1'b1;
                else if (ones[0]) grp_en[GRP_EVEN_L] = 1'b1;
                else grp_en[GRP_ODD_L] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/thermo_stage_array.sv
module thermo_stage_array
    import thermo_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  fill,
    input  logic [NUM_GRP_EN-1:0] grp_en,
    output logic [WIDTH-1:0]      code
);
    logic [WIDTH-1:0] code_d, code_q;
    logic [WIDTH-1:0] from_lo;
    logic [WIDTH-1:0] from_hi;

    assign from_lo = {code_q[WIDTH-2:0], 1'b1};
    assign from_hi = {1'b0, code_q[WIDTH-1:1]};

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        localparam bit ODD = (i % 2) == 1;
        logic take_r;
        logic take_l;
        assign take_r = ODD ? grp_en[GRP_ODD_R] : grp_en[GRP_EVEN_R];
        assign take_l = ODD ? grp_en[GRP_ODD_L] : grp_en[GRP_EVEN_L];
        assign code_d[i] = clr    ? 1'b0 :
                           fill   ? 1'b1 :
                           take_r ? from_lo[i] :
                           take_l ? from_hi[i] :
                                    code_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

    assign code = code_q;
endmodule

// File: rtl/thermo_shifter.sv
module thermo_shifter
    import thermo_pkg::*;
#(
    parameter int WIDTH = 64,
    localparam int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fill,
    input  logic             step_en,
    input  logic             dir_left,
    output logic [WIDTH-1:0] code,
    output logic [CNT_W-1:0] ones,
    output logic             clipped
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WIDTH);

    typedef struct packed {
        logic [CNT_W-1:0] ones;
        logic             clipped;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_GRP_EN-1:0] grp_en;
    logic                  blocked;

    thermo_group_gen #(.WIDTH(WIDTH)) u_grp (
        .clr      (clr),
        .fill     (fill),
        .step_en  (step_en),
        .dir_left (dir_left),
        .ones     (st_q.ones),
        .grp_en   (grp_en),
        .blocked  (blocked)
    );

    thermo_stage_array #(.WIDTH(WIDTH)) u_arr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .fill   (fill),
        .grp_en (grp_en),
        .code   (code)
    );

    always_comb begin
        st_d         = st_q;
        st_d.clipped = blocked;
        if (clr)                                  st_d.ones = '0;
        else if (fill)                            st_d.ones = FULL;
        else if (grp_en[GRP_EVEN_R] || grp_en[GRP_ODD_R]) st_d.ones = st_q.ones + 1'b1;
        else if (grp_en[GRP_EVEN_L] || grp_en[GRP_ODD_L]) st_d.ones = st_q.ones - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ones    = st_q.ones;
    assign clipped = st_q.clipped;
endmodule

// File: rtl/thermo_shifter_chk.sv
module thermo_shifter_chk
    import thermo_pkg::*;
#(
    parameter int WIDTH = 64,
    localparam int CNT_W = $clog2(WIDTH + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  clr,
    input logic                  fill,
    input logic                  step_en,
    input logic                  dir_left,
    input logic [WIDTH-1:0]      code,
    input logic [CNT_W-1:0]      ones,
    input logic                  clipped,
    input logic [NUM_GRP_EN-1:0] grp_en
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WIDTH);

    always_comb begin
        if (!rst_n) begin
            p_rst_zero_r1: assert (code == '0 && ones == '0 && !clipped);
        end
    end

    p_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (code == '0 && ones == '0));

    p_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && fill) |=> (code == '1 && ones == FULL));

    p_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !dir_left && !clr && !fill && ones != FULL)
        |=> (ones == $past(ones) + 1'b1));

    p_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && dir_left && !clr && !fill && ones != '0)
        |=> (ones == $past(ones) - 1'b1));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !clr && !fill) |=> ($stable(code) && $stable(ones)));

    p_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !clr && !fill &&
         ((!dir_left && ones == FULL) || (dir_left && ones == '0)))
        |=> (clipped && $stable(code)));

    p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ones == CNT_W'($countones(code))) && ((code & (code + 1'b1)) == '0));

    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_en));

    p_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dir_left ? (grp_en[GRP_EVEN_R] == 1'b0 && grp_en[GRP_ODD_R] == 1'b0)
                 : (grp_en[GRP_EVEN_L] == 1'b0 && grp_en[GRP_ODD_L] == 1'b0));

    p_alt_r_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grp_en[GRP_EVEN_R] |=> !grp_en[GRP_EVEN_R]);

    p_alt_l_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grp_en[GRP_ODD_L] |=> !grp_en[GRP_ODD_L]);
endmodule

bind thermo_shifter thermo_shifter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .fill     (fill),
    .step_en  (step_en),
    .dir_left (dir_left),
    .code     (code),
    .ones     (ones),
    .clipped  (clipped),
    .grp_en   (grp_en)
);

// File: tb/sim_thermo_shifter.sv
`timescale 1ns/1ps
module sim_thermo_shifter;
    localparam int WIDTH = 64;
    localparam int CNT_W = $clog2(WIDTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr = 1'b0;
    logic             fill = 1'b0;
    logic             step_en = 1'b0;
    logic             dir_left = 1'b0;
    logic [WIDTH-1:0] code;
    logic [CNT_W-1:0] ones;
    logic             clipped;

    int tests = 0;
    int fails = 0;
    int exp_n = 0;
    bit exp_clip = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    thermo_shifter #(.WIDTH(WIDTH)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .fill(fill),
        .step_en(step_en), .dir_left(dir_left),
        .code(code), .ones(ones), .clipped(clipped)
    );

    function automatic logic [WIDTH-1:0] therm(input int n);
        logic [WIDTH-1:0] v = '0;
        for (int i = 0; i < WIDTH; i++) if (i < n) v[i] = 1'b1;
        return v;
    endfunction

    function automatic bit valid_therm(input logic [WIDTH-1:0] v);
        bit seen0 = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (!v[i]) seen0 = 1'b1;
            else if (seen0) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // apply one cycle at negedge, model the result, compare at next negedge
    task automatic cyc(input bit c, input bit f, input bit s, input bit d, input string req);
        int prev = exp_n;
        clr = c; fill = f; step_en = s; dir_left = d;
        @(posedge clk);
        exp_clip = 1'b0;
        if (c) exp_n = 0;
        else if (f) exp_n = WIDTH;
        else if (s) begin
            if (!d) begin
                if (exp_n == WIDTH) exp_clip = 1'b1; else exp_n++;
            end else begin
                if (exp_n == 0) exp_clip = 1'b1; else exp_n--;
            end
        end
        @(negedge clk);
        check(req, code, therm(exp_n));
        check(req, WIDTH'(ones), WIDTH'(exp_n));
        check("R7", WIDTH'(clipped), WIDTH'(exp_clip));
        check("R8", WIDTH'(valid_therm(code)), WIDTH'(1));
        check("R8", WIDTH'($countones(code)), WIDTH'(ones));
        if (!c && !f) begin
            int dlt = exp_n - prev;
            check("R8", WIDTH'((dlt >= -1 && dlt <= 1) ? 1 : 0), WIDTH'(1));
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", code, '0);
        check("R1", WIDTH'(ones), '0);
        check("R1", WIDTH'(clipped), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: two rightward steps from empty set stages 0 and 1
        cyc(0, 0, 1, 0, "R9");
        cyc(0, 0, 1, 0, "R9");
        check("R9", code, WIDTH'(3));
        // R6: hold
        cyc(0, 0, 0, 0, "R6");
        cyc(0, 0, 0, 1, "R6");
        // R5: left steps to empty then R7 clip
        cyc(0, 0, 1, 1, "R5");
        cyc(0, 0, 1, 1, "R5");
        cyc(0, 0, 1, 1, "R7");
        check("R7", WIDTH'(clipped), WIDTH'(1));
        // R4 walk to full, then clip
        for (int i = 0; i < WIDTH; i++) cyc(0, 0, 1, 0, "R4");
        check("R4", code, '1);
        cyc(0, 0, 1, 0, "R7");
        cyc(0, 0, 1, 0, "R7");
        // R5 walk back to empty
        for (int i = 0; i < WIDTH; i++) cyc(0, 0, 1, 1, "R5");
        // R3 fill beats step; R2 clr beats fill and step
        cyc(0, 1, 1, 1, "R3");
        cyc(1, 1, 1, 0, "R2");
        cyc(0, 1, 0, 0, "R3");
        cyc(1, 0, 0, 0, "R2");

        // constrained random
        for (int k = 0; k < 3000; k++) begin
            int r = $urandom_range(0, 99);
            bit dl = ($urandom_range(0, 99) < ((k / 200) % 2 == 0 ? 25 : 75));
            if (r < 2)       cyc(1, $urandom_range(0, 1) == 1, 1, dl, "R2");
            else if (r < 4)  cyc(0, 1, $urandom_range(0, 1) == 1, dl, "R3");
            else if (r < 15) cyc(0, 0, 0, dl, "R6");
            else             cyc(0, 0, 1, dl, dl ? "R5" : "R4");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule